// File: doc/BRIEF.md
# Address-Gated Bidirectional Data Bus Bridge

This block lets an 8-bit external port serve as a buffered extension of a microcontroller's local data bus. It acts as a tri-state transceiver. Each port pin n is tied to data bit n. The block passes data only when two conditions hold: software has set the enable bit of a mode register, and the current bus address falls inside one of two fixed address windows.

The MCU strobes set the transfer direction on every cycle. During a read strobe, the port pins drive the MCU data bus. During a write strobe, the MCU data bus drives the port pins. In every other case both sides are released. Each window is a base and mask pair fixed by parameters. The mode register sits at its own address, qualified by its own chip select. It is the only clocked state in the block. The output enables and the data paths are purely combinational.

Top module: `pio_bus_bridge`

## Requirements
- R1: After reset the enable bit is 0. Until it is written, both output enables stay 0 for every address and strobe.
- R2: The enable bit is captured on a rising clock edge only when `mode_cs`=1, `wr`=1 and `addr` equals `MODE_ADDR` (default 16'h0040). It takes the value of `mcu_data_in[7]`. Writes at any other address leave it unchanged.
- R3: While the enable bit is 0, `mcu_data_oe` and `pin_oe` are both 0, whatever the address and strobes.
- R4: An address hits when `(addr & WINk_MASK) == WINk_BASE` for window 0 (defaults 16'h8000 / 16'hFF00) or window 1 (defaults 16'hA000 / 16'hF000). An address that hits neither window leaves both enables at 0.
- R5: Read transfer: with the bridge active, `rd`=1 and `wr`=0, `mcu_data_oe`=1 and `mcu_data_out[n]` = `pin_in[n]` for n = 0..7.
- R6: Write transfer: with the bridge active, `wr`=1 and `rd`=0, `pin_oe`=1 and `pin_out[n]` = `mcu_data_in[n]` for n = 0..7.
- R7: When `rd` and `wr` are both 1, neither side drives.
- R8: With no strobe, neither side drives. Whenever a side does not drive, its data output reads 0.
- R9: The enables and data outputs follow the address, strobes and data inputs in the same cycle, with no clock latency.
- R10: While `mode_cs`=1, the bridge does not drive either side, even inside a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mode register |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | MCU address bus |
| rd | input | 1 | MCU read strobe, active high |
| wr | input | 1 | MCU write strobe, active high |
| mode_cs | input | 1 | Chip select for the mode register |
| mcu_data_in | input | 8 | Data bus as driven by the MCU |
| mcu_data_out | output | 8 | Data this block puts on the MCU bus |
| mcu_data_oe | output | 1 | Drive enable toward the MCU bus |
| pin_in | input | 8 | Values sensed on the port pins |
| pin_out | output | 8 | Data this block drives on the port pins |
| pin_oe | output | 1 | Drive enable toward the port pins |

## Verification
All transfer results (R3–R10) are combinational, so they are due in the same cycle as the stimulus. The bench changes inputs on the falling clock edge and samples one time unit later, well before the next rising edge. A mode register write (R1, R2) takes effect one rising edge after it is presented. The bench therefore checks its effect only after that edge, using a probe cycle that does not touch the register.

// File: rtl/pio_bridge_pkg.sv
package pio_bridge_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned EN_BIT = DATA_W - 1;
  localparam int unsigned NUM_WIN = 2;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [1:0] {
    DIR_IDLE  = 2'b00,
    DIR_READ  = 2'b01,
    DIR_WRITE = 2'b10
  } dir_e;
endpackage

// File: rtl/pio_mode_reg.sv
module pio_mode_reg
  import pio_bridge_pkg::*;
#(
  parameter addr_t MODE_ADDR = 16'h0040
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  mode_cs,
  input  logic  wr,
  input  addr_t addr,
  input  logic  en_bit_in,
  output logic  mode_en
);
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  logic       wr_hit;
  logic       en_d;
  logic       en_q;

  // Reset asserts asynchronously and is released on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_comb begin
    wr_hit = mode_cs && wr && (addr == MODE_ADDR);
    en_d   = wr_hit ? en_bit_in : en_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) en_q <= 1'b0;
    else             en_q <= en_d;
  end

  assign mode_en = en_q;

  // R2
  mode_capture_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_cs && wr && addr == MODE_ADDR) |=> (mode_en == $past(en_bit_in)));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(mode_cs && wr) |=> $stable(mode_en));
endmodule

// File: rtl/pio_win_decode.sv
module pio_win_decode
  import pio_bridge_pkg::*;
#(
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASE = {16'hA000, 16'h8000},
  parameter logic [NUM_WIN*ADDR_W-1:0] WIN_MASK = {16'hF000, 16'hFF00}
) (
  input  addr_t              addr,
  output logic [NUM_WIN-1:0] win_hit,
  output logic               any_hit
);
  for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
    localparam addr_t BASE_K = WIN_BASE[k*ADDR_W +: ADDR_W];
    localparam addr_t MASK_K = WIN_MASK[k*ADDR_W +: ADDR_W];
    assign win_hit[k] = ((addr & MASK_K) == BASE_K);
  end

  assign any_hit = |win_hit;
endmodule

// File: rtl/pio_dir_ctrl.sv
module pio_dir_ctrl
  import pio_bridge_pkg::*;
(
  input  logic  mode_en,
  input  logic  any_hit,
  input  logic  mode_cs,
  input  logic  rd,
  input  logic  wr,
  input  data_t mcu_data_in,
  input  data_t pin_in,
  output data_t mcu_data_out,
  output logic  mcu_data_oe,
  output data_t pin_out,
  output logic  pin_oe
);
  logic active;
  dir_e dir;

  always_comb begin
    active = mode_en && any_hit && !mode_cs;
    dir    = DIR_IDLE;
    if (active) begin
      unique case ({wr, rd})
        2'b01:   dir = DIR_READ;
        2'b10:   dir = DIR_WRITE;
        default: dir = DIR_IDLE;
      endcase
    end
  end

  // Bit n of one side maps straight onto bit n of the other.
  for (genvar n = 0; n < DATA_W; n++) begin : g_lane
    assign mcu_data_out[n] = (dir == DIR_READ)  && pin_in[n];
    assign pin_out[n]      = (dir == DIR_WRITE) && mcu_data_in[n];
  end

  assign mcu_data_oe = (dir == DIR_READ);
  assign pin_oe      = (dir == DIR_WRITE);
endmodule

// File: rtl/pio_bus_bridge.sv
module pio_bus_bridge
  import pio_bridge_pkg::*;
#(
  parameter addr_t MODE_ADDR = 16'h0040,
  parameter addr_t WIN0_BASE = 16'h8000,
  parameter addr_t WIN0_MASK = 16'hFF00,
  parameter addr_t WIN1_BASE = 16'hA000,
  parameter addr_t WIN1_MASK = 16'hF000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] addr,
  input  logic        rd,
  input  logic        wr,
  input  logic        mode_cs,
  input  logic [7:0]  mcu_data_in,
  output logic [7:0]  mcu_data_out,
  output logic        mcu_data_oe,
  input  logic [7:0]  pin_in,
  output logic [7:0]  pin_out,
  output logic        pin_oe
);
  logic               mode_en;
  logic [NUM_WIN-1:0] win_hit;
  logic               any_hit;

  pio_mode_reg #(.MODE_ADDR(MODE_ADDR)) u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_cs   (mode_cs),
    .wr        (wr),
    .addr      (addr),
    .en_bit_in (mcu_data_in[EN_BIT]),
    .mode_en   (mode_en)
  );

  pio_win_decode #(
    .WIN_BASE ({WIN1_BASE, WIN0_BASE}),
    .WIN_MASK ({WIN1_MASK, WIN0_MASK})
  ) u_dec (
    .addr    (addr),
    .win_hit (win_hit),
    .any_hit (any_hit)
  );

  pio_dir_ctrl u_dir (
    .mode_en      (mode_en),
    .any_hit      (any_hit),
    .mode_cs      (mode_cs),
    .rd           (rd),
    .wr           (wr),
    .mcu_data_in  (mcu_data_in),
    .pin_in       (pin_in),
    .mcu_data_out (mcu_data_out),
    .mcu_data_oe  (mcu_data_oe),
    .pin_out      (pin_out),
    .pin_oe       (pin_oe)
  );

  // R3
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_en |-> !(mcu_data_oe || pin_oe));

  // R4
  outside_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_hit == '0) |-> !(mcu_data_oe || pin_oe));

  // R5
  read_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mcu_data_oe |-> (rd && !wr && mcu_data_out == pin_in));

  // R6
  write_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pin_oe |-> (wr && !rd && pin_out == mcu_data_in));

  // R7
  strobe_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && wr) |-> !(mcu_data_oe || pin_oe));

  // R10
  cfg_cycle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_cs |-> !(mcu_data_oe || pin_oe));
endmodule

// File: tb/pio_bus_bridge_tb.sv
module pio_bus_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;

  // Fields: addr[16], rd, wr, mcu_din[8], pin[8], exp_moe, exp_mout[8], exp_poe, exp_pout[8]
  localparam logic [51:0] VEC [NVEC] = '{
    {16'h8012, 1'b1, 1'b0, 8'h11, 8'h5A, 1'b1, 8'h5A, 1'b0, 8'h00},
    {16'h8012, 1'b0, 1'b1, 8'hA5, 8'h22, 1'b0, 8'h00, 1'b1, 8'hA5},
    {16'hA7FF, 1'b1, 1'b0, 8'h00, 8'h3C, 1'b1, 8'h3C, 1'b0, 8'h00},
    {16'hAFFF, 1'b0, 1'b1, 8'hC3, 8'hFF, 1'b0, 8'h00, 1'b1, 8'hC3},
    {16'h8112, 1'b1, 1'b0, 8'h44, 8'h99, 1'b0, 8'h00, 1'b0, 8'h00},
    {16'hB000, 1'b0, 1'b1, 8'h77, 8'h66, 1'b0, 8'h00, 1'b0, 8'h00},
    {16'h8000, 1'b1, 1'b1, 8'h0F, 8'hF0, 1'b0, 8'h00, 1'b0, 8'h00},
    {16'h80FF, 1'b0, 1'b0, 8'h81, 8'h18, 1'b0, 8'h00, 1'b0, 8'h00},
    {16'h9000, 1'b1, 1'b0, 8'h01, 8'h80, 1'b0, 8'h00, 1'b0, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        rd, wr, mode_cs;
  logic [7:0]  mcu_data_in, pin_in;
  logic [7:0]  mcu_data_out, pin_out;
  logic        mcu_data_oe, pin_oe;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;

  pio_bus_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd(rd), .wr(wr), .mode_cs(mode_cs),
    .mcu_data_in(mcu_data_in), .mcu_data_out(mcu_data_out), .mcu_data_oe(mcu_data_oe),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [17:0] got, input logic [17:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got moe=%b mout=%h poe=%b pout=%h expected moe=%b mout=%h poe=%b pout=%h",
               req, got[17], got[16:9], got[8], got[7:0], exp[17], exp[16:9], exp[8], exp[7:0]);
    end
  endtask

  function automatic logic [17:0] outs();
    return {mcu_data_oe, mcu_data_out, pin_oe, pin_out};
  endfunction

  task automatic drive(input logic [15:0] a, input logic r, input logic w,
                       input logic cs, input logic [7:0] md, input logic [7:0] pd);
    @(negedge clk);
    addr = a; rd = r; wr = w; mode_cs = cs; mcu_data_in = md; pin_in = pd;
    #1;
  endtask

  // Present a mode register write, let one rising edge capture it, then idle.
  task automatic mode_write(input logic [15:0] a, input logic [7:0] val);
    drive(a, 1'b0, 1'b1, 1'b1, val, 8'h00);
    drive(16'h0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
  endtask

  task automatic probe_read(input string req, input logic exp_on);
    drive(16'h8010, 1'b1, 1'b0, 1'b0, 8'h00, 8'h6B);
    check(req, outs(), exp_on ? {1'b1, 8'h6B, 1'b0, 8'h00} : 18'h0);
  endtask

  initial begin
    rst_n = 1'b0; addr = '0; rd = 0; wr = 0; mode_cs = 0; mcu_data_in = '0; pin_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: disabled out of reset, in a window, with a read strobe
    probe_read("R1", 1'b0);
    drive(16'hA123, 1'b0, 1'b1, 1'b0, 8'h5F, 8'h00);
    check("R1", outs(), 18'h0);

    // R3: bit 7 clear, other bits set -> still disabled
    mode_write(16'h0040, 8'h7F);
    probe_read("R3", 1'b0);

    // R2: write at a wrong address is ignored
    mode_write(16'h0041, 8'h80);
    probe_read("R2", 1'b0);

    // R2: proper write enables
    mode_write(16'h0040, 8'h80);
    probe_read("R2", 1'b1);

    // Table: R4..R9, all combinational (R9: sampled in the same cycle)
    for (int i = 0; i < NVEC; i++) begin
      logic [51:0] v;
      v = VEC[i];
      drive(v[51:36], v[35], v[34], 1'b0, v[33:26], v[25:18]);
      check("R4-R9 vector", outs(), v[17:0]);
    end

    // R9: change pin data mid-cycle, output follows without a clock
    drive(16'h8020, 1'b1, 1'b0, 1'b0, 8'h00, 8'h12);
    pin_in = 8'hED; #1;
    check("R9", outs(), {1'b1, 8'hED, 1'b0, 8'h00});

    // R10: chip select high inside a window blocks the bridge
    drive(16'h8020, 1'b1, 1'b0, 1'b1, 8'h00, 8'h44);
    check("R10", outs(), 18'h0);

    // R8: no strobe in window 1, data outputs zero
    drive(16'hA000, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hFF);
    check("R8", outs(), 18'h0);

    // R3: clear the enable bit again
    mode_write(16'h0040, 8'h00);
    probe_read("R3", 1'b0);

    // R1: reset in mid-run clears an enabled bridge
    mode_write(16'h0040, 8'h80);
    probe_read("R2", 1'b1);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    probe_read("R1", 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule